// File: doc/BRIEF.md
# MSI Shared-Register Interrupt Collector

This block gathers message-signalled interrupts into a small set of pending-status words. A PCI-side agent posts a write to one doorbell address. The low nine bits of the written word name a status word and a bit within that word. The block sets that bit, and the bit stays set until software collects it. Each status word drives its own level interrupt line toward the upstream interrupt controller. The line is high while any bit of its word is set.

The static input `layout_sel` chooses one of two field layouts for the doorbell word. It has to match the way addresses were handed to the endpoints. The CPU collects interrupts through a read channel that is separate from the write channel. A read of a status word returns its contents and empties it in the same operation, which acknowledges every source in that word at once. Words move over both channels as 32-bit values with the most significant byte at the lowest address, so no lane swapping happens inside the block.

Top module: `msi_collector`

## Requirements
- R1: After reset, every status word is zero, every `cascade_irq` line is low and `rd_ack` is low.
- R2: With `layout_sel`=0, a doorbell write sets bit `wr_data[4:0]` of status word `wr_data[8:5]`. Bits 31..9 of the data have no effect.
- R3: With `layout_sel`=1, a doorbell write sets bit `wr_data[8:4]` of status word `wr_data[3:0]`.
- R4: The doorbell is the byte address 0x140 only. A write to any other address changes no status word.
- R5: A doorbell write whose decoded word index is NUM_REGS or higher is dropped.
- R6: Status word k sits at byte address k×16 when WIDE_STRIDE=1 and k×4 when WIDE_STRIDE=0. A read strobe gives `rd_ack`=1 on the next cycle, with `rd_data` equal to the word's value before the read. Without a strobe, `rd_ack` is 0 on the next cycle.
- R7: A read of a status word clears it. A second read returns zero, and the word's line is low from the cycle after the clearing read.
- R8: If a doorbell write and a clearing read hit the same word in the same cycle, the read returns the old value and the newly written bit stays pending.
- R9: `cascade_irq[k]` is high exactly while status word k is nonzero. It holds its value in any cycle with no read and no write.
- R10: A read of an address that maps to no status word returns zero and clears nothing. This includes misaligned addresses, indices at or above NUM_REGS, and the doorbell itself.
- R11: Several doorbell writes to one word accumulate as an OR of their bits until the word is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| layout_sel | input | 1 | Doorbell field layout: 0 uses index [8:5] and bit [4:0]; 1 uses index [3:0] and bit [8:4] |
| wr_valid | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data word |
| rd_valid | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read result, valid while `rd_ack` is high |
| rd_ack | output | 1 | Read result valid, one cycle after the strobe |
| cascade_irq | output | NUM_REGS | One level interrupt per status word |

## Verification
The bench builds the block with NUM_REGS=12 and WIDE_STRIDE=1. With twelve words, the 4-bit index can encode values 12 to 15, so the drop rule for out-of-range indices can be exercised in both layouts. The 16-byte stride also leaves addresses 0x0C0 and up, and addresses that are not multiples of 16, as unmapped reads. A random write/read mix switches `layout_sel` every few hundred operations. The directed cases cover a write and a clearing read landing together on one word, junk in the upper data bits, and writes aimed at status-word addresses rather than the doorbell.

// File: rtl/msi_pkg.sv
package msi_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned SRC_W      = 5;
  localparam int unsigned REG_IDX_W  = 4;
  localparam int unsigned MAX_REGS   = 1 << REG_IDX_W;
  localparam int unsigned DB_FIELD_W = REG_IDX_W + SRC_W;

  typedef enum logic {
    LAYOUT_LEGACY = 1'b0,
    LAYOUT_ALT    = 1'b1
  } layout_e;

  typedef struct packed {
    logic [REG_IDX_W-1:0] reg_idx;
    logic [SRC_W-1:0]     src_idx;
  } db_target_t;

  // Split the doorbell field into word index and source bit.
  function automatic db_target_t decode_db(input logic [DB_FIELD_W-1:0] fld,
                                           input layout_e lay);
    db_target_t t;
    if (lay == LAYOUT_ALT) begin
      t.reg_idx = fld[REG_IDX_W-1:0];
      t.src_idx = fld[DB_FIELD_W-1:REG_IDX_W];
    end else begin
      t.reg_idx = fld[DB_FIELD_W-1:SRC_W];
      t.src_idx = fld[SRC_W-1:0];
    end
    return t;
  endfunction

endpackage

// File: rtl/msi_rst_sync.sv
module msi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/msi_doorbell_dec.sv
module msi_doorbell_dec
  import msi_pkg::*;
#(
  parameter int unsigned NUM_REGS  = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DB_OFFSET = 32'h140
) (
  input  logic                             wr_valid,
  input  logic [ADDR_W-1:0]                wr_addr,
  input  logic [WORD_W-1:0]                wr_data,
  input  layout_e                          layout_sel,
  output logic [NUM_REGS-1:0][WORD_W-1:0]  set_vec
);

  logic        db_hit;
  db_target_t  tgt;
  logic [WORD_W-1:0] src_onehot;
  logic        unused_hi;

  assign db_hit     = wr_valid && (wr_addr == ADDR_W'(DB_OFFSET));
  assign tgt        = decode_db(wr_data[DB_FIELD_W-1:0], layout_sel);
  assign src_onehot = WORD_W'(1) << tgt.src_idx;
  assign unused_hi  = ^wr_data[WORD_W-1:DB_FIELD_W];

  // Indices at or above NUM_REGS match no slice and fall away.
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_slice
    assign set_vec[k] = (db_hit && (tgt.reg_idx == REG_IDX_W'(k))) ? src_onehot : '0;
  end

endmodule

// File: rtl/msi_read_port.sv
module msi_read_port
  import msi_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 16,
  parameter int unsigned ADDR_W      = 12,
  parameter bit          WIDE_STRIDE = 1'b1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rd_valid,
  input  logic [ADDR_W-1:0]               rd_addr,
  input  logic [NUM_REGS-1:0][WORD_W-1:0] stat_q,
  output logic [NUM_REGS-1:0]             clr_vec,
  output logic [WORD_W-1:0]               rd_data,
  output logic                            rd_ack
);

  localparam int unsigned STRIDE = WIDE_STRIDE ? 16 : 4;

  logic [NUM_REGS-1:0] sel;
  logic [WORD_W-1:0]   data_d;
  logic [WORD_W-1:0]   data_q;
  logic                ack_q;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
    assign sel[k] = rd_valid && (rd_addr == ADDR_W'(k * STRIDE));
  end

  // At most one select is high, so an OR tree forms the mux.
  always_comb begin
    data_d = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      data_d = data_d | (sel[k] ? stat_q[k] : '0);
    end
  end

  assign clr_vec = sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= rd_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        data_q <= '0;
    else if (rd_valid) data_q <= data_d;
  end

  assign rd_data = data_q;
  assign rd_ack  = ack_q;

endmodule

// File: rtl/msi_status_bank.sv
module msi_status_bank
  import msi_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_REGS-1:0][WORD_W-1:0] set_vec,
  input  logic [NUM_REGS-1:0]             clr_vec,
  output logic [NUM_REGS-1:0][WORD_W-1:0] stat_q,
  output logic [NUM_REGS-1:0]             cascade
);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    logic [WORD_W-1:0] word_d;
    logic [WORD_W-1:0] word_q;
    logic              word_en;

    // Clear first, then merge new bits, so a same-cycle write survives.
    always_comb begin
      word_en = clr_vec[k] || (|set_vec[k]);
      word_d  = (clr_vec[k] ? '0 : word_q) | set_vec[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       word_q <= '0;
      else if (word_en) word_q <= word_d;
    end

    assign stat_q[k]  = word_q;
    assign cascade[k] = |word_q;
  end

endmodule

// File: rtl/msi_collector.sv
module msi_collector
  import msi_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 16,
  parameter int unsigned ADDR_W      = 12,
  parameter bit          WIDE_STRIDE = 1'b1,
  parameter int unsigned DB_OFFSET   = 32'h140
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                layout_sel,
  input  logic                wr_valid,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic                rd_valid,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [31:0]         rd_data,
  output logic                rd_ack,
  output logic [NUM_REGS-1:0] cascade_irq
);

  logic                            rst_sync_n;
  logic [NUM_REGS-1:0][WORD_W-1:0] set_vec;
  logic [NUM_REGS-1:0]             clr_vec;
  logic [NUM_REGS-1:0][WORD_W-1:0] stat_q;

  msi_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  msi_doorbell_dec #(
    .NUM_REGS  (NUM_REGS),
    .ADDR_W    (ADDR_W),
    .DB_OFFSET (DB_OFFSET)
  ) u_db_dec (
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .layout_sel (layout_e'(layout_sel)),
    .set_vec    (set_vec)
  );

  msi_read_port #(
    .NUM_REGS    (NUM_REGS),
    .ADDR_W      (ADDR_W),
    .WIDE_STRIDE (WIDE_STRIDE)
  ) u_rd_port (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .stat_q   (stat_q),
    .clr_vec  (clr_vec),
    .rd_data  (rd_data),
    .rd_ack   (rd_ack)
  );

  msi_status_bank #(
    .NUM_REGS (NUM_REGS)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .stat_q  (stat_q),
    .cascade (cascade_irq)
  );

endmodule

// File: rtl/msi_collector_chk.sv
module msi_collector_chk #(
  parameter int unsigned NUM_REGS    = 16,
  parameter int unsigned ADDR_W      = 12,
  parameter bit          WIDE_STRIDE = 1'b1,
  parameter int unsigned DB_OFFSET   = 32'h140
) (
  input logic                clk,
  input logic                rst_n,
  input logic                layout_sel,
  input logic                wr_valid,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [31:0]         wr_data,
  input logic                rd_valid,
  input logic [ADDR_W-1:0]   rd_addr,
  input logic [31:0]         rd_data,
  input logic                rd_ack,
  input logic [NUM_REGS-1:0] cascade_irq
);

  localparam int unsigned STRIDE = WIDE_STRIDE ? 16 : 4;

  logic       db_hit;
  logic [3:0] idx;
  logic       rd_mapped;
  logic       unused_chk;

  assign db_hit     = (wr_addr == ADDR_W'(DB_OFFSET));
  assign idx        = layout_sel ? wr_data[3:0] : wr_data[8:5];
  assign rd_mapped  = ((rd_addr & ADDR_W'(STRIDE - 1)) == '0) &&
                      (int'(rd_addr) < int'(NUM_REGS * STRIDE));
  assign unused_chk = ^{wr_data[31:9], wr_data[4]};

  AST_ACK_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_ack);  // R6
  AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rd_ack);  // R6
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_mapped) |=> (rd_data == 32'd0));  // R10
  AST_IDLE_HOLDS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !rd_valid) |=> $stable(cascade_irq));  // R9
  AST_OUT_OF_RANGE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && db_hit && (int'(idx) >= int'(NUM_REGS)) && !rd_valid) |=> $stable(cascade_irq));  // R5
  AST_OFF_DOORBELL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !db_hit && !rd_valid) |=> $stable(cascade_irq));  // R4

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_line
    AST_FALL_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cascade_irq[k]) |-> $past(rd_valid && (rd_addr == ADDR_W'(k * STRIDE))));  // R7
    AST_RISE_NEEDS_DOORBELL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cascade_irq[k]) |-> $past(wr_valid && db_hit));  // R2
  end

endmodule

bind msi_collector msi_collector_chk #(
  .NUM_REGS    (NUM_REGS),
  .ADDR_W      (ADDR_W),
  .WIDE_STRIDE (WIDE_STRIDE),
  .DB_OFFSET   (DB_OFFSET)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .layout_sel  (layout_sel),
  .wr_valid    (wr_valid),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .rd_valid    (rd_valid),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data),
  .rd_ack      (rd_ack),
  .cascade_irq (cascade_irq)
);

// File: tb/msi_collector_tb.sv
`timescale 1ns/1ps
module msi_collector_tb;

  localparam int NREG = 12;
  localparam int AW   = 12;

  logic            clk;
  logic            rst_n;
  logic            layout_sel;
  logic            wr_valid;
  logic [AW-1:0]   wr_addr;
  logic [31:0]     wr_data;
  logic            rd_valid;
  logic [AW-1:0]   rd_addr;
  logic [31:0]     rd_data;
  logic            rd_ack;
  logic [NREG-1:0] cascade_irq;

  int          n_cmp;
  int          n_bad;
  bit          done;
  logic [31:0] model [NREG];

  msi_collector #(
    .NUM_REGS    (NREG),
    .ADDR_W      (AW),
    .WIDE_STRIDE (1'b1),
    .DB_OFFSET   (32'h140)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .layout_sel  (layout_sel),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_valid    (rd_valid),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .rd_ack      (rd_ack),
    .cascade_irq (cascade_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int exp_idx(input logic [31:0] d, input logic lay);
    return lay ? int'(d[3:0]) : int'(d[8:5]);
  endfunction

  function automatic int exp_bit(input logic [31:0] d, input logic lay);
    return lay ? int'(d[8:4]) : int'(d[4:0]);
  endfunction

  function automatic logic [NREG-1:0] exp_lines();
    logic [NREG-1:0] v;
    for (int k = 0; k < NREG; k++) v[k] = (model[k] != 32'd0);
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, check at the next falling edge.
  task automatic step(input logic wv, input logic [AW-1:0] wa, input logic [31:0] wd,
                      input logic rv, input logic [AW-1:0] ra, input string req);
    logic [31:0] exp_rd;
    int ri;
    int wi;
    wr_valid = wv; wr_addr = wa; wr_data = wd;
    rd_valid = rv; rd_addr = ra;
    exp_rd = 32'd0;
    if (rv && (ra[3:0] == 4'd0) && (int'(ra) < NREG * 16)) begin
      ri = int'(ra) / 16;
      exp_rd = model[ri];
      model[ri] = 32'd0;
    end
    if (wv && (wa == 12'h140)) begin
      wi = exp_idx(wd, layout_sel);
      if (wi < NREG) model[wi] = model[wi] | (32'd1 << exp_bit(wd, layout_sel));
    end
    @(posedge clk);
    @(negedge clk);
    check({req, " ack"}, {31'd0, rd_ack}, {31'd0, rv});
    if (rv) check({req, " data"}, rd_data, exp_rd);
    check({req, " lines"}, 32'(cascade_irq), 32'(exp_lines()));
    wr_valid = 1'b0;
    rd_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    n_cmp = 0; n_bad = 0; done = 1'b0;
    for (int k = 0; k < NREG; k++) model[k] = 32'd0;
    rst_n = 1'b0; layout_sel = 1'b0;
    wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    rd_valid = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: quiet after reset
    check("R1 lines", 32'(cascade_irq), 32'd0);
    check("R1 ack", {31'd0, rd_ack}, 32'd0);
    for (int k = 0; k < NREG; k++) step(0, '0, '0, 1, AW'(k * 16), "R1");

    // R2: legacy layout, junk above bit 8
    layout_sel = 1'b0;
    step(1, 12'h140, 32'hFFFF_FE67, 0, '0, "R2");
    step(0, '0, '0, 1, 12'h030, "R2");

    // R11: accumulation, then R7 second read empty
    step(1, 12'h140, 32'h0A0, 0, '0, "R11");
    step(1, 12'h140, 32'h0A9, 0, '0, "R11");
    step(1, 12'h140, 32'h0A0, 0, '0, "R11");
    step(0, '0, '0, 1, 12'h050, "R11");
    step(0, '0, '0, 1, 12'h050, "R7");

    // R3: alternate layout
    layout_sel = 1'b1;
    step(1, 12'h140, 32'h112, 0, '0, "R3");
    step(0, '0, '0, 1, 12'h020, "R3");

    // R4: writes off the doorbell
    layout_sel = 1'b0;
    step(1, 12'h144, 32'h067, 0, '0, "R4");
    step(1, 12'h030, 32'h067, 0, '0, "R4");
    step(0, '0, '0, 1, 12'h030, "R4");

    // R5: index beyond the configured words, both layouts
    step(1, 12'h140, 32'h1A1, 0, '0, "R5");
    layout_sel = 1'b1;
    step(1, 12'h140, 32'h01F, 0, '0, "R5");
    layout_sel = 1'b0;

    // R8: write and clearing read on one word in one cycle
    step(1, 12'h140, 32'h0A0, 0, '0, "R8");
    step(1, 12'h140, 32'h0A4, 1, 12'h050, "R8");
    step(0, '0, '0, 1, 12'h050, "R8");

    // R9: line holds while idle, R6 highest word address
    step(1, 12'h140, 32'h160, 0, '0, "R9");
    for (int i = 0; i < 3; i++) step(0, '0, '0, 0, '0, "R9");
    step(0, '0, '0, 1, 12'h0B0, "R6");

    // R10: unmapped reads neither return data nor clear
    step(1, 12'h140, 32'h0E1, 0, '0, "R10");
    step(0, '0, '0, 1, 12'h074, "R10");
    step(0, '0, '0, 1, 12'h0C0, "R10");
    step(0, '0, '0, 1, 12'h140, "R10");
    step(0, '0, '0, 1, 12'h070, "R10");

    // Random mix, R6 and the rest via the model
    for (int i = 0; i < 1500; i++) begin
      logic          wv;
      logic          rv;
      logic [AW-1:0] wa;
      logic [AW-1:0] ra;
      if (i % 300 == 0) layout_sel = ~layout_sel;
      wv = ($urandom % 3) != 0;
      rv = ($urandom % 3) == 0;
      wa = (($urandom % 8) == 0) ? AW'($urandom) : 12'h140;
      ra = (($urandom % 10) == 0) ? AW'($urandom) : AW'(($urandom % 14) * 16);
      step(wv, wa, $urandom, rv, ra, "R6");
    end

    // Drain every word so the final state is known
    for (int k = 0; k < NREG; k++) step(0, '0, '0, 1, AW'(k * 16), "R7");
    check("R7 lines", 32'(cascade_irq), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule